// File: doc/BRIEF.md
# Hot-Plug Slot Event Interrupt Notifier

This block holds the slot control and slot status words of a downstream port that supports hot-plug. It records hot-plug events (button presses, presence changes, power faults, link-state changes and command completions) in status flags and decides when software must be told. The decision rests on one stored "notify" bit. That bit is true when the master hot-plug interrupt enable is on and at least one status flag is both set and individually enabled in the control word.

The block acts only when a freshly computed notify value differs from the stored one. With message signalling disabled, a legacy interrupt level follows the notify bit. With message signalling enabled, the block emits a one-cycle message request on a false-to-true change, and the legacy level is left where it was. Software clears status flags by writing ones. A write to the control word raises a command-completed event. A one written to the interlock command bit flips the interlock status flag and is not stored. The configuration transaction layer, message formatting and the physical presence and link hardware sit outside this block.

Top module: `slot_hp_notifier`

## Requirements
- R1: While `rstN` is low, and after it is released with no other stimulus, `slotCtrl`, `slotStatus`, `intxOut` and `msiReq` are all zero.
- R2: A high bit on `evtIn` at a position in the supported mask sets the same status bit. The supported positions are 0 attention button, 1 power fault, 2 latch sensor change, 3 presence change, 4 command completed and 8 link state change. Bits outside the mask are ignored.
- R3: The notify condition is true when control bit 5 (the master hot-plug interrupt enable) is set and the AND of control, status and the supported mask is non-zero.
- R4: With `msiEnable` low, `intxOut` takes the new notify value whenever that value changes. With `msiEnable` high, `intxOut` holds its value.
- R5: With `msiEnable` high, `msiReq` pulses for exactly one cycle when the notify condition goes from false to true. A true-to-false change gives no pulse.
- R6: An event whose status bit is already set causes no re-evaluation and no notification.
- R7: A status write clears every supported status bit written as 1.
- R8: Writing control bit 11 as 1 toggles status bit 7. Control bit 11 always reads 0.
- R9: Every control write stores the written value (bit 11 excepted) and sets status bit 4 (command completed).
- R10: If an event and a status write clearing the same bit fall in the same cycle, the bit stays set. Several events in one cycle produce at most one `msiReq` pulse.
- R11: The register words update one clock after a write or event, and the notify outputs update on the clock after that.
- R12: An event that arrives while its enable is off is signalled when a later control write turns the enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 16 | Hot-plug event pulses, one bit per status position |
| ctrlWrEn | input | 1 | Write strobe for the slot control word |
| ctrlWrData | input | 16 | Data for a slot control write |
| staWrEn | input | 1 | Write strobe for the slot status word (write 1 to clear) |
| staWrData | input | 16 | Data for a slot status write |
| msiEnable | input | 1 | Message signalled interrupts enabled |
| intxOut | output | 1 | Legacy interrupt level |
| msiReq | output | 1 | One-cycle message interrupt request |
| slotCtrl | output | 16 | Current slot control word |
| slotStatus | output | 16 | Current slot status word |

## Verification
Event recording and write-1-to-clear can hit the same status bit in the same cycle. The bench provokes this by pulsing the presence-change event in the same cycle that a status write clears that bit. It judges the result by the status word read back two clocks later, which must still show the bit, and by the absence of any message request. A second collision drives three events together into an enabled notify path. The scoreboard expects one message strobe and then a quiet cycle.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  localparam int REG_W = 16;

  // status / control bit positions
  localparam int ABP_B  = 0;
  localparam int PFD_B  = 1;
  localparam int MRL_B  = 2;
  localparam int PDC_B  = 3;
  localparam int CC_B   = 4;
  localparam int HPIE_B = 5;
  localparam int ILS_B  = 7;
  localparam int DLL_B  = 8;
  localparam int ILCK_B = 11;

  localparam logic [REG_W-1:0] DEFAULT_EVT_MASK =
    REG_W'((1 << ABP_B) | (1 << PFD_B) | (1 << MRL_B) |
           (1 << PDC_B) | (1 << CC_B)  | (1 << DLL_B));

  typedef struct packed {
    logic             ctrlLoad;
    logic [REG_W-1:0] ctrlData;
    logic [REG_W-1:0] clrMask;
    logic             ilockFlip;
    logic             ccSet;
  } dpStrobe_t;
endpackage

// File: rtl/slot_hp_dp.sv
module slot_hp_dp
  import slot_hp_pkg::*;
#(
  parameter logic [REG_W-1:0] EVT_MASK = DEFAULT_EVT_MASK
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] evtIn,
  input  dpStrobe_t        strobe,
  output logic             newSet,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] staQ
);
  localparam logic [REG_W-1:0] CC_BIT  = REG_W'(1) << CC_B;
  localparam logic [REG_W-1:0] ILS_BIT = REG_W'(1) << ILS_B;

  logic [REG_W-1:0] evtHits;
  logic [REG_W-1:0] setBits;
  logic [REG_W-1:0] staNext;

  always_comb begin
    evtHits = evtIn & EVT_MASK;
    setBits = evtHits | (strobe.ccSet ? (CC_BIT & EVT_MASK) : '0);
    newSet  = |(setBits & ~staQ);
    // set has priority over a same-cycle clear
    staNext = (staQ & ~strobe.clrMask) | setBits;
    if (strobe.ilockFlip) staNext = staNext ^ ILS_BIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      staQ  <= '0;
    end else begin
      staQ <= staNext;
      if (strobe.ctrlLoad) ctrlQ <= strobe.ctrlData;
    end
  end

  assert_evt_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtIn & EVT_MASK)) |=> ((staQ & $past(evtIn & EVT_MASK)) == $past(evtIn & EVT_MASK)));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.clrMask & ~setBits)) |=> ((staQ & $past(strobe.clrMask & ~setBits)) == '0));

  assert_ilock_flip_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ilockFlip |=> (staQ[ILS_B] != $past(staQ[ILS_B])));

  assert_ilock_not_stored_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlLoad |=> !ctrlQ[ILCK_B]);
endmodule

// File: rtl/slot_hp_ctl.sv
module slot_hp_ctl
  import slot_hp_pkg::*;
#(
  parameter logic [REG_W-1:0] EVT_MASK = DEFAULT_EVT_MASK
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [REG_W-1:0] ctrlWrData,
  input  logic             staWrEn,
  input  logic [REG_W-1:0] staWrData,
  input  logic             msiEnable,
  input  logic             newSet,
  input  logic [REG_W-1:0] slotCtrl,
  input  logic [REG_W-1:0] slotStatus,
  output dpStrobe_t        strobe,
  output logic             intxOut,
  output logic             msiReq
);
  localparam logic [REG_W-1:0] ILCK_BIT = REG_W'(1) << ILCK_B;

  logic evalReq;
  logic condReg;
  logic newCond;

  always_comb begin
    strobe.ctrlLoad  = ctrlWrEn;
    strobe.ctrlData  = ctrlWrData & ~ILCK_BIT;
    strobe.clrMask   = staWrEn ? (staWrData & EVT_MASK) : '0;
    strobe.ilockFlip = ctrlWrEn && ctrlWrData[ILCK_B];
    strobe.ccSet     = ctrlWrEn;
    newCond = slotCtrl[HPIE_B] && (|(slotCtrl & slotStatus & EVT_MASK));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evalReq <= 1'b0;
      condReg <= 1'b0;
      intxOut <= 1'b0;
      msiReq  <= 1'b0;
    end else begin
      evalReq <= ctrlWrEn || staWrEn || newSet;
      msiReq  <= 1'b0;
      if (evalReq && (newCond != condReg)) begin
        condReg <= newCond;
        if (!msiEnable) intxOut <= newCond;
        else            msiReq  <= newCond;
      end
    end
  end

  assert_msi_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    msiReq |-> (condReg && !$past(condReg) && $past(msiEnable)));

  assert_msi_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    msiReq |=> !msiReq);

  assert_intx_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(intxOut) |-> ((intxOut == condReg) && !$past(msiEnable)));

  assert_eval_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(condReg) |-> $past(evalReq));

  assert_cc_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> slotStatus[CC_B]);
endmodule

// File: rtl/slot_hp_notifier.sv
module slot_hp_notifier
  import slot_hp_pkg::*;
#(
  parameter logic [REG_W-1:0] EVT_MASK = DEFAULT_EVT_MASK
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] evtIn,
  input  logic             ctrlWrEn,
  input  logic [REG_W-1:0] ctrlWrData,
  input  logic             staWrEn,
  input  logic [REG_W-1:0] staWrData,
  input  logic             msiEnable,
  output logic             intxOut,
  output logic             msiReq,
  output logic [REG_W-1:0] slotCtrl,
  output logic [REG_W-1:0] slotStatus
);
  dpStrobe_t strobe;
  logic      newSet;

  slot_hp_ctl #(.EVT_MASK(EVT_MASK)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .staWrEn    (staWrEn),
    .staWrData  (staWrData),
    .msiEnable  (msiEnable),
    .newSet     (newSet),
    .slotCtrl   (slotCtrl),
    .slotStatus (slotStatus),
    .strobe     (strobe),
    .intxOut    (intxOut),
    .msiReq     (msiReq)
  );

  slot_hp_dp #(.EVT_MASK(EVT_MASK)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .evtIn  (evtIn),
    .strobe (strobe),
    .newSet (newSet),
    .ctrlQ  (slotCtrl),
    .staQ   (slotStatus)
  );
endmodule

// File: tb/tb_slot_hp_notifier.sv
module tb_slot_hp_notifier;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtIn = '0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic        staWrEn = 1'b0;
  logic [15:0] staWrData = '0;
  logic        msiEnable = 1'b0;
  logic        intxOut, msiReq;
  logic [15:0] slotCtrl, slotStatus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic        intx;
    logic        msi;
    logic [15:0] ctl;
    logic [15:0] sta;
    string       tag;
  } exp_t;
  exp_t q[$];

  slot_hp_notifier dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .staWrEn(staWrEn), .staWrData(staWrData),
    .msiEnable(msiEnable), .intxOut(intxOut), .msiReq(msiReq),
    .slotCtrl(slotCtrl), .slotStatus(slotStatus)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input exp_t e);
    checks++;
    if (intxOut !== e.intx || msiReq !== e.msi || slotCtrl !== e.ctl || slotStatus !== e.sta) begin
      errors++;
      $display("FAIL %s: got intx=%b msi=%b ctl=%h sta=%h, expected intx=%b msi=%b ctl=%h sta=%h",
               e.tag, intxOut, msiReq, slotCtrl, slotStatus, e.intx, e.msi, e.ctl, e.sta);
    end
  endtask

  // monitor: pops expected items as their sample cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        checks++; errors++;
        $display("FAIL %s: sample missed, actual cycle %0d expected %0d", e.tag, cyc, e.due);
      end else compare(e);
    end
  end

  // driver: applies one stimulus cycle, outputs are expected two clocks later (R11)
  task automatic step(input logic [15:0] evt, input logic cw, input logic [15:0] cwd,
                      input logic sw, input logic [15:0] swd, input logic msi,
                      input logic eIntx, input logic eMsi, input logic [15:0] eCtl,
                      input logic [15:0] eSta, input string tag);
    exp_t e;
    @(negedge clk);
    evtIn = evt; ctrlWrEn = cw; ctrlWrData = cwd;
    staWrEn = sw; staWrData = swd; msiEnable = msi;
    e = '{cyc + 2, eIntx, eMsi, eCtl, eSta, tag};
    q.push_back(e);
    e = '{cyc + 3, eIntx, 1'b0, eCtl, eSta, {tag, " (quiet cycle)"}};
    q.push_back(e);
    @(negedge clk);
    evtIn = '0; ctrlWrEn = 1'b0; staWrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkIdle(input string tag);
    exp_t e;
    e = '{0, 1'b0, 1'b0, 16'h0, 16'h0, tag};
    compare(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 during reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1 after release");

    step(16'h0001, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 16'h0001, "R2 button event, enable off");
    step(16'h0000, 1, 16'h0021, 0, 0, 0, 1, 0, 16'h0021, 16'h0011, "R12 R9 R3 enable later signals pending event");
    step(16'h0000, 0, 0, 1, 16'h0001, 0, 0, 0, 16'h0021, 16'h0010, "R7 R4 clear drops level");
    step(16'h0001, 0, 0, 0, 0, 0, 1, 0, 16'h0021, 16'h0011, "R4 event raises level");
    step(16'h0001, 0, 0, 0, 0, 0, 1, 0, 16'h0021, 16'h0011, "R6 repeat event on set bit");
    step(16'h0000, 0, 0, 1, 16'h0001, 1, 1, 0, 16'h0021, 16'h0010, "R4 R5 fall with msi on, level held");
    step(16'h0001, 0, 0, 0, 0, 1, 1, 1, 16'h0021, 16'h0011, "R5 rise with msi on");
    step(16'h0000, 0, 0, 1, 16'h0011, 1, 1, 0, 16'h0021, 16'h0000, "R7 R5 clear all, no message");
    step(16'h0000, 1, 16'h0128, 0, 0, 1, 1, 0, 16'h0128, 16'h0010, "R9 R3 completion not enabled");
    step(16'h410A, 0, 0, 0, 0, 1, 1, 1, 16'h0128, 16'h011A, "R10 R2 three events one message");
    step(16'h0000, 1, 16'h0928, 0, 0, 1, 1, 0, 16'h0128, 16'h019A, "R8 interlock toggle on");
    step(16'h0000, 1, 16'h0928, 0, 0, 1, 1, 0, 16'h0128, 16'h011A, "R8 interlock toggle off");
    step(16'h0008, 0, 0, 1, 16'h0008, 1, 1, 0, 16'h0128, 16'h011A, "R10 event beats same-cycle clear");
    step(16'h0000, 0, 0, 1, 16'h011A, 0, 0, 0, 16'h0128, 16'h0000, "R4 level falls with msi off");
    step(16'h0000, 1, 16'h0008, 0, 0, 0, 0, 0, 16'h0008, 16'h0010, "R9 write without master enable");
    step(16'h0008, 0, 0, 0, 0, 0, 0, 0, 16'h0008, 16'h0018, "R3 master enable off blocks level");

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdle("R1 reset mid-run");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule